// File: doc/BRIEF.md
# Dual-Slope PWM Timer with One Compare Channel

This block is an 8-bit counter that sweeps up from zero to its maximum and then back down, over and over. It drives one waveform pin from a single compare channel. Each time the counter passes the compare value the pin is set or cleared. Which of the two happens depends on the sweep direction, so the pulse stays centred in the period. That gives symmetric, phase-correct PWM. The counter advances only on cycles where an external prescaler raises a count-enable strobe.

Software controls the block through a few plain inputs. A 2-bit output-mode field picks one of three things: disconnect the pin and pass a port level through instead, normal polarity, or inverted polarity. The compare value is written into a holding register and becomes active only when the counter reaches its top. This avoids glitched periods. The counter itself can be read at any time and overwritten at any time. An overwrite masks the compare on the next count, so a value written equal to the compare value does not cause a spurious toggle.

Top module: `pcpwm_timer`

## Requirements
- R1: After a synchronous reset the counter reads 0, the direction is upward, the internal waveform level is 0, both compare registers are 0, and all three event flags are 0.
- R2: On each count-enable cycle the counter steps through 0,1,...,254,255,254,...,1,0,1,... Top (255) and bottom (0) each appear for exactly one count, and the direction reverses on leaving them.
- R3: On a cycle with count-enable low and no counter write, the counter, the direction and the waveform level all keep their values.
- R4: A counter write (`tcnt_we`=1) loads `tcnt_wdata`, which is readable on `tcnt_q` in the next cycle. A write takes priority over a count-enable in the same cycle, leaves the direction unchanged and produces no event flag.
- R5: The first count-enable cycle after a counter write does not raise a compare match. The flag stays 0 and the waveform level is not changed, even when the counter equals the compare value.
- R6: With `com_mode` 2'b00 or the reserved 2'b01, `wave_out` equals `port_val`.
- R7: With `com_mode` 2'b10, a match on a count cycle while the direction is up clears the waveform, and a match while the direction is down sets it. `wave_out` shows this level.
- R8: With `com_mode` 2'b11, a match while the direction is up sets the waveform, and a match while the direction is down clears it.
- R9: When the active compare value is 255 and `com_mode[1]` is 1, no match is raised. On the count cycle at 255 the waveform takes the level that a down-direction match would give: set for 2'b10, clear for 2'b11.
- R10: A compare write (`ocr_we`) goes to a holding register. That value becomes the active compare value only on a count-enable cycle in which the counter is at 255. Compares made on that same cycle still use the old value.
- R11: `top_flag`, `bot_flag` and `match_flag` are one-cycle pulses that appear in the cycle after a count-enable cycle in which, respectively, the counter was at 255, the counter was at 0, or an unmasked match occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-enable strobe from the prescaler |
| com_mode | input | 2 | Output mode: 00/01 pass port level, 10 normal, 11 inverted |
| port_val | input | 1 | Port level driven on the pin while disconnected |
| ocr_we | input | 1 | Write strobe for the compare holding register |
| ocr_wdata | input | 8 | Compare value to write |
| tcnt_we | input | 1 | Counter write strobe |
| tcnt_wdata | input | 8 | Counter value to write |
| tcnt_q | output | 8 | Current counter value |
| wave_out | output | 1 | Waveform pin level |
| top_flag | output | 1 | Pulse: counter was at top on the last count |
| bot_flag | output | 1 | Pulse: counter was at bottom on the last count |
| match_flag | output | 1 | Pulse: unmasked compare match on the last count |

## Verification
Full up/down periods are run in both polarities with a mid-range compare value. This separates an up-direction match from a down-direction match, and it shows whether top and bottom are each visited once. Compare writes made in mid-sweep show whether the new value waits for top. A compare value of 255 shows whether the top action replaces the ignored match. Counter writes placed on or just below the compare value show the masked next compare apart from the normal one that follows. A write made together with count-enable tells write priority apart from counting. Idle gaps and toggling of the port level in both disconnected modes check hold behaviour and pass-through.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_RSVD   = 2'b01,
        OM_CLR_UP = 2'b10,
        OM_SET_UP = 2'b11
    } outmode_e;

    typedef struct packed {
        logic at_top;
        logic at_bot;
        logic match;
    } evt_t;

    // Level a compare match leaves on the pin in an attached mode.
    function automatic logic match_level(input outmode_e m, input logic up);
        return up ? m[0] : ~m[0];
    endfunction

    // Level applied at top when the compare value sits at top.
    function automatic logic top_level(input outmode_e m);
        return ~m[0];
    endfunction

endpackage

// File: rtl/pcpwm_counter.sv
module pcpwm_counter #(
    parameter int W = pcpwm_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_q,
    output logic         up_q,
    output logic         blk_q,
    output logic         tick
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = '0;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_nx;
    logic         up_nx;

    assign tick = cnt_en && !wr_en;

    always_comb begin
        cnt_nx = cnt_q;
        up_nx  = up_q;
        if (up_q) begin
            if (cnt_q == TOP) begin
                up_nx  = 1'b0;
                cnt_nx = cnt_q - ONE;
            end else begin
                cnt_nx = cnt_q + ONE;
            end
        end else begin
            if (cnt_q == BOT) begin
                up_nx  = 1'b1;
                cnt_nx = cnt_q + ONE;
            end else begin
                cnt_nx = cnt_q - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= BOT;
            up_q  <= 1'b1;
            blk_q <= 1'b0;
        end else if (wr_en) begin
            cnt_q <= wr_data;
            blk_q <= 1'b1;
        end else if (cnt_en) begin
            cnt_q <= cnt_nx;
            up_q  <= up_nx;
            blk_q <= 1'b0;
        end
    end

    // R3: idle cycles hold counter and direction
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !wr_en) |=> ($stable(cnt_q) && $stable(up_q)));

    // R2: each count moves the counter by exactly one
    a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> (((cnt_q - $past(cnt_q)) == ONE) || (($past(cnt_q) - cnt_q) == ONE)));

    // R4: a write loads the written value and keeps direction
    a_r4_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt_q == $past(wr_data) && $stable(up_q)));

endmodule

// File: rtl/pcpwm_ocr_buf.sv
module pcpwm_ocr_buf #(
    parameter int W = pcpwm_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         tick,
    input  logic         at_top,
    output logic [W-1:0] act_q
);
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            act_q  <= '0;
        end else begin
            if (wr_en) begin
                hold_q <= wr_data;
            end
            if (tick && at_top) begin
                act_q <= hold_q;
            end
        end
    end

    // R10: active compare only changes on a count at top
    a_r10_load_at_top: assert property (@(posedge clk) disable iff (rst)
        !(tick && at_top) |=> $stable(act_q));

endmodule

// File: rtl/pcpwm_wavegen.sv
module pcpwm_wavegen
    import pcpwm_pkg::*;
#(
    parameter int W = pcpwm_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic         up,
    input  logic         blk,
    input  logic [W-1:0] ocr_act,
    input  outmode_e     mode,
    output logic         wave_q,
    output evt_t         evt_q
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = '0;

    logic attached;
    logic ocr_at_top;
    logic hit;
    evt_t evt_nx;

    assign attached   = mode[1];
    assign ocr_at_top = attached && (ocr_act == TOP);
    assign hit        = tick && !blk && (cnt == ocr_act) && !ocr_at_top;

    always_comb begin
        evt_nx.at_top = tick && (cnt == TOP);
        evt_nx.at_bot = tick && (cnt == BOT);
        evt_nx.match  = hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q <= 1'b0;
            evt_q  <= '0;
        end else begin
            evt_q <= evt_nx;
            if (tick && attached) begin
                if (ocr_at_top && cnt == TOP) begin
                    wave_q <= top_level(mode);
                end else if (hit) begin
                    wave_q <= match_level(mode, up);
                end
            end
        end
    end

    // R5: a masked count raises no match
    a_r5_masked_no_match: assert property (@(posedge clk) disable iff (rst)
        (tick && blk) |=> !evt_q.match);

    // R11: top and bottom events never coincide
    a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(evt_q.at_top && evt_q.at_bot));

    // R3: waveform holds without a count
    a_r3_wave_idle: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(wave_q));

    // R9: compare value at top never raises a match in attached modes
    a_r9_top_no_match: assert property (@(posedge clk) disable iff (rst)
        (tick && ocr_at_top) |=> !evt_q.match);

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int W = pcpwm_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic [1:0]   com_mode,
    input  logic         port_val,
    input  logic         ocr_we,
    input  logic [W-1:0] ocr_wdata,
    input  logic         tcnt_we,
    input  logic [W-1:0] tcnt_wdata,
    output logic [W-1:0] tcnt_q,
    output logic         wave_out,
    output logic         top_flag,
    output logic         bot_flag,
    output logic         match_flag
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt;
    logic         up;
    logic         blk;
    logic         tick;
    logic [W-1:0] ocr_act;
    logic         wave_lvl;
    evt_t         evt;
    outmode_e     mode;

    assign mode = outmode_e'(com_mode);

    pcpwm_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .wr_en   (tcnt_we),
        .wr_data (tcnt_wdata),
        .cnt_q   (cnt),
        .up_q    (up),
        .blk_q   (blk),
        .tick    (tick)
    );

    pcpwm_ocr_buf #(.W(W)) u_ocr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ocr_we),
        .wr_data (ocr_wdata),
        .tick    (tick),
        .at_top  (cnt == TOP),
        .act_q   (ocr_act)
    );

    pcpwm_wavegen #(.W(W)) u_wave (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cnt     (cnt),
        .up      (up),
        .blk     (blk),
        .ocr_act (ocr_act),
        .mode    (mode),
        .wave_q  (wave_lvl),
        .evt_q   (evt)
    );

    assign tcnt_q     = cnt;
    assign wave_out   = mode[1] ? wave_lvl : port_val;
    assign top_flag   = evt.at_top;
    assign bot_flag   = evt.at_bot;
    assign match_flag = evt.match;

    // R6: disconnected modes pass the port level
    a_r6_passthrough: assert property (@(posedge clk) disable iff (rst)
        !com_mode[1] |-> (wave_out == port_val));

endmodule

// File: tb/pcpwm_timer_tb.sv
module pcpwm_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cnt_en;
    logic [1:0] com_mode;
    logic       port_val;
    logic       ocr_we;
    logic [7:0] ocr_wdata;
    logic       tcnt_we;
    logic [7:0] tcnt_wdata;
    logic [7:0] tcnt_q;
    logic       wave_out, top_flag, bot_flag, match_flag;

    int n_vec = 0;
    int n_bad = 0;

    // expected state, built from the requirements
    logic [7:0] m_cnt, m_act, m_buf;
    logic       m_up, m_wave, m_blk, m_top, m_bot, m_match;

    always #2.5 clk = ~clk;

    pcpwm_timer dut_i (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .com_mode(com_mode),
        .port_val(port_val), .ocr_we(ocr_we), .ocr_wdata(ocr_wdata),
        .tcnt_we(tcnt_we), .tcnt_wdata(tcnt_wdata), .tcnt_q(tcnt_q),
        .wave_out(wave_out), .top_flag(top_flag), .bot_flag(bot_flag),
        .match_flag(match_flag)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic exp_w;
        exp_w = com_mode[1] ? m_wave : port_val;
        check(tag, "tcnt_q", tcnt_q, m_cnt);
        check(tag, "wave_out", wave_out, exp_w);
        check(tag, "top_flag", top_flag, m_top);
        check(tag, "bot_flag", bot_flag, m_bot);
        check(tag, "match_flag", match_flag, m_match);
    endtask

    task automatic model_tick();
        logic at_top_case;
        at_top_case = com_mode[1] && (m_act == 8'hFF);
        m_top   = (m_cnt == 8'hFF);
        m_bot   = (m_cnt == 8'h00);
        m_match = !m_blk && (m_cnt == m_act) && !at_top_case;
        if (com_mode[1]) begin
            if (at_top_case && m_cnt == 8'hFF) m_wave = ~com_mode[0];
            else if (m_match) m_wave = m_up ? com_mode[0] : ~com_mode[0];
        end
        m_blk = 1'b0;
        if (m_cnt == 8'hFF) m_act = m_buf;
        if (m_up) begin
            if (m_cnt == 8'hFF) begin m_up = 1'b0; m_cnt = m_cnt - 8'd1; end
            else m_cnt = m_cnt + 8'd1;
        end else begin
            if (m_cnt == 8'h00) begin m_up = 1'b1; m_cnt = m_cnt + 8'd1; end
            else m_cnt = m_cnt - 8'd1;
        end
    endtask

    task automatic clear_flags();
        m_top = 1'b0; m_bot = 1'b0; m_match = 1'b0;
    endtask

    // one count: drive at negedge, check at the following negedge
    task automatic step(input string tag);
        cnt_en = 1'b1;
        model_tick();
        @(negedge clk);
        cnt_en = 1'b0;
        check_all(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic write_ocr(input logic [7:0] v);
        ocr_we = 1'b1; ocr_wdata = v; m_buf = v;
        @(negedge clk);
        ocr_we = 1'b0;
        clear_flags();
    endtask

    task automatic write_cnt(input logic [7:0] v, input logic with_en, input string tag);
        tcnt_we = 1'b1; tcnt_wdata = v; cnt_en = with_en;
        @(negedge clk);
        tcnt_we = 1'b0; cnt_en = 1'b0;
        m_cnt = v; m_blk = 1'b1;
        clear_flags();
        check_all(tag);
    endtask

    task automatic t_reset();
        rst = 1'b1; cnt_en = 1'b0; com_mode = 2'b00; port_val = 1'b0;
        ocr_we = 1'b0; ocr_wdata = '0; tcnt_we = 1'b0; tcnt_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_act = 0; m_buf = 0; m_up = 1; m_wave = 0; m_blk = 0;
        clear_flags();
        @(negedge clk);
        check_all("R1");
        com_mode = 2'b10;
        check("R1", "wave level", wave_out, 0);
    endtask

    task automatic t_sweep_normal();
        com_mode = 2'b10; port_val = 1'b1;
        write_ocr(8'd100);
        run(1024, "R2 R7 R10 R11");
    endtask

    task automatic t_hold();
        logic [7:0] c0;
        logic w0;
        c0 = tcnt_q; w0 = wave_out;
        repeat (5) begin
            @(negedge clk);
            clear_flags();
            check("R3", "tcnt_q hold", tcnt_q, c0);
            check("R3", "wave hold", wave_out, w0);
            check_all("R3");
        end
    endtask

    task automatic t_sweep_inverted();
        com_mode = 2'b11;
        run(520, "R8 R11");
    endtask

    task automatic t_disconnected();
        for (int k = 0; k < 40; k++) begin
            com_mode = (k < 20) ? 2'b00 : 2'b01;
            port_val = k[0] ^ k[2];
            step("R6");
        end
    endtask

    task automatic t_buffer_mid();
        com_mode = 2'b10;
        run(60, "R10");
        write_ocr(8'd40);
        run(600, "R10 R7");
    endtask

    task automatic t_ocr_top();
        com_mode = 2'b10;
        write_ocr(8'hFF);
        run(600, "R9");
        com_mode = 2'b11;
        run(600, "R9");
    endtask

    task automatic t_write_mask();
        com_mode = 2'b10;
        write_ocr(8'd200);
        run(520, "R10");
        // place counter on compare value going up: next count is masked
        while (!m_up) step("R5");
        write_cnt(8'd200, 1'b0, "R4");
        step("R5");
        check("R5", "masked match", match_flag, 0);
        run(20, "R5");
        // one below: the match on the second count is not masked
        while (!m_up) step("R5");
        write_cnt(8'd199, 1'b0, "R4");
        step("R5");
        step("R5");
        check("R5", "unmasked match", match_flag, 1);
        run(20, "R5");
    endtask

    task automatic t_write_priority();
        write_cnt(8'd17, 1'b1, "R4");
        check("R4", "write beats count", tcnt_q, 17);
        run(8, "R4");
        write_cnt(8'h00, 1'b1, "R4");
        run(8, "R4");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_sweep_normal();
                t_hold();
                t_sweep_inverted();
                t_disconnected();
                t_buffer_mid();
                t_ocr_top();
                t_hold();
                t_write_mask();
                t_write_priority();
            end
            begin
                repeat (100000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule